// File: doc/BRIEF.md
# Fault Status and Response Arbiter

This block holds the fault flags of a sensor's status word and decides, from those flags, what an acceleration data request returns. The flags are: initialization in progress, reset occurred, internal error and offset error. The block also produces two control outputs. One stops the arming logic from being updated. The other disables the pulse output.

Each flag follows its own persistence rule:

- **Initialization in progress** clears by itself when initialization completes.
- **Reset occurred** clears when the status word is read.
- **Internal error** has three causes, and each keeps its own latch:
  - A shadow-memory CRC failure is permanent.
  - A writable-register CRC failure seen while the configuration lock is set clears only on reset.
  - A writable-register CRC failure seen while unlocked, or a self-test failure, clears on a status read once the fault condition has gone.
- **Offset error** clears on the first status read after the fault has gone.

A small state machine tracks the boot flags through four named states:

- `S_BOOT` (both flags set).
- `S_BOOT_ACK` (initializing, reset flag already read).
- `S_RST_PEND` (initialized, reset flag not yet read).
- `S_RUN` (both clear).

Its transitions are:

- `init_done` moves `S_BOOT` to `S_RST_PEND` and `S_BOOT_ACK` to `S_RUN`.
- A status read moves `S_BOOT` to `S_BOOT_ACK` and `S_RST_PEND` to `S_RUN`.
- Both in the same cycle move `S_BOOT` straight to `S_RUN`.

Top module: `fsr_fault_arbiter`

## Requirements
- R1: After reset, `stat_o` is 4'b0011: bit 0 is the initialization flag and bit 1 is the reset flag. `resp_o` is 2'b01 (internal error present), and `arm_inhibit_o` and `pulse_dis_o` are both 1.
- R2: The initialization flag (`stat_o[0]`) clears one cycle after `init_done_i` is seen high, and nothing but reset sets it again.
- R3: A read (`stat_rd_i` high) returns on `stat_o` the values held before the read. The reset flag (`stat_o[1]`) clears in the cycle after a read.
- R4: While `stat_o[0]` or `stat_o[1]` is set, `resp_o` is 2'b01 and both `arm_inhibit_o` and `pulse_dis_o` are 1. With no flag set, `resp_o` is 2'b00 (normal data) and both controls are 0.
- R5: `otp_crc_fail_i` sets the internal-error flag (`stat_o[2]`), and no status read clears it.
- R6: `wr_crc_fail_i` while `lock_i` is high sets `stat_o[2]`. Only reset clears it.
- R7: `wr_crc_fail_i` while `lock_i` is low sets `stat_o[2]`. It clears on a read made after the fault input has dropped.
- R8: `selftest_fail_i` sets `stat_o[2]` and makes `resp_o` 2'b10 (self-test error). It clears only on a read made after the input has dropped.
- R9: `offset_fault_i` sets the offset flag (`stat_o[3]`) and makes `resp_o` 2'b01. The flag stays set after the input drops and clears on the next read.
- R10: CRC, self-test and offset flags set `arm_inhibit_o` and leave `pulse_dis_o` at 0.
- R11: When the flags call for both 2'b01 and 2'b10, `resp_o` is 2'b01.
- R12: A fault input high in the same cycle as a read leaves its flag set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| init_done_i | input | 1 | Initialization complete |
| stat_rd_i | input | 1 | Status word read strobe |
| lock_i | input | 1 | Configuration lock bit |
| otp_crc_fail_i | input | 1 | Shadow-memory CRC failure |
| wr_crc_fail_i | input | 1 | Writable-register CRC failure |
| selftest_fail_i | input | 1 | Self-test failure present |
| offset_fault_i | input | 1 | Offset monitor fault present |
| stat_o | output | 4 | Flags: {offset, internal error, reset occurred, initializing} |
| resp_o | output | 2 | Data request response code |
| arm_inhibit_o | output | 1 | Arming update inhibit |
| pulse_dis_o | output | 1 | Pulse output disable |

## Verification
The bench builds the block with its default response-code width of 2 and the default code values, so every one of the three response codes can be seen at the port.

Directed sequences walk each persistence rule. They cover a read during a fault and a read after it has gone, a lock change between two CRC faults, and a reset that clears a locked CRC flag.

Random fault and read traffic, with occasional resets, exercises all four boot states. It also reaches overlapping faults, where the priority between the codes decides the response.

// File: rtl/fsr_pkg.sv
package fsr_pkg;

    parameter int RESP_W = 2;

    localparam logic [RESP_W-1:0] RESP_NORMAL = RESP_W'(0);
    localparam logic [RESP_W-1:0] RESP_IEP    = RESP_W'(1);
    localparam logic [RESP_W-1:0] RESP_STE    = RESP_W'(2);

    // latched fault sources
    localparam int SRC_OTP  = 0;
    localparam int SRC_WLK  = 1;
    localparam int SRC_WOP  = 2;
    localparam int SRC_ST   = 3;
    localparam int SRC_OFS  = 4;
    localparam int N_SRC    = 5;

    localparam int STAT_W   = 4;

    typedef enum logic {
        CLR_ON_READ,
        CLR_NEVER
    } clr_mode_e;

    typedef enum logic [1:0] {
        S_BOOT,
        S_BOOT_ACK,
        S_RST_PEND,
        S_RUN
    } boot_state_e;

endpackage

// File: rtl/fsr_fault_cell.sv
module fsr_fault_cell
    import fsr_pkg::*;
#(
    parameter clr_mode_e MODE = CLR_ON_READ
) (
    input  logic clk,
    input  logic rst_n,
    input  logic evt_i,
    input  logic rd_i,
    output logic q_o
);

    logic q;

    generate
        if (MODE == CLR_ON_READ) begin : g_rd
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n)     q <= 1'b0;
                else if (evt_i) q <= 1'b1;
                else if (rd_i)  q <= 1'b0;
            end
        end else begin : g_hold
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n)     q <= 1'b0;
                else if (evt_i) q <= 1'b1;
            end
            logic unused_rd;
            assign unused_rd = rd_i;
        end
    endgenerate

    assign q_o = q;

endmodule

// File: rtl/fsr_boot_fsm.sv
module fsr_boot_fsm
    import fsr_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic done_i,
    input  logic rd_i,
    output logic init_o,
    output logic rst_flag_o
);

    boot_state_e state, state_nx;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= S_BOOT;
        else        state <= state_nx;
    end

    always_comb begin
        state_nx = state;
        unique case (state)
            S_BOOT: begin
                if (done_i && rd_i) state_nx = S_RUN;
                else if (done_i)    state_nx = S_RST_PEND;
                else if (rd_i)      state_nx = S_BOOT_ACK;
            end
            S_BOOT_ACK: if (done_i) state_nx = S_RUN;
            S_RST_PEND: if (rd_i)   state_nx = S_RUN;
            S_RUN:      state_nx = S_RUN;
            default:    state_nx = S_BOOT;
        endcase
    end

    always_comb begin
        init_o     = 1'b0;
        rst_flag_o = 1'b0;
        unique case (state)
            S_BOOT:     begin init_o = 1'b1; rst_flag_o = 1'b1; end
            S_BOOT_ACK: init_o = 1'b1;
            S_RST_PEND: rst_flag_o = 1'b1;
            S_RUN:      ;
            default:    begin init_o = 1'b1; rst_flag_o = 1'b1; end
        endcase
    end

endmodule

// File: rtl/fsr_resp_arb.sv
module fsr_resp_arb
    import fsr_pkg::*;
(
    input  logic               busy_i,
    input  logic [N_SRC-1:0]   src_i,
    output logic [RESP_W-1:0]  resp_o,
    output logic               arm_inh_o,
    output logic               pulse_dis_o
);

    logic iep_req, ste_req;

    always_comb begin
        iep_req = busy_i | src_i[SRC_OTP] | src_i[SRC_WLK]
                | src_i[SRC_WOP] | src_i[SRC_OFS];
        ste_req = src_i[SRC_ST];
        if (iep_req)      resp_o = RESP_IEP;
        else if (ste_req) resp_o = RESP_STE;
        else              resp_o = RESP_NORMAL;
        arm_inh_o   = busy_i | (|src_i);
        pulse_dis_o = busy_i;
    end

endmodule

// File: rtl/fsr_fault_arbiter.sv
module fsr_fault_arbiter
    import fsr_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              init_done_i,
    input  logic              stat_rd_i,
    input  logic              lock_i,
    input  logic              otp_crc_fail_i,
    input  logic              wr_crc_fail_i,
    input  logic              selftest_fail_i,
    input  logic              offset_fault_i,
    output logic [STAT_W-1:0] stat_o,
    output logic [RESP_W-1:0] resp_o,
    output logic              arm_inhibit_o,
    output logic              pulse_dis_o
);

    logic             init_f, rst_f;
    logic [N_SRC-1:0] evt, src;

    always_comb begin
        evt          = '0;
        evt[SRC_OTP] = otp_crc_fail_i;
        evt[SRC_WLK] = wr_crc_fail_i & lock_i;
        evt[SRC_WOP] = wr_crc_fail_i & ~lock_i;
        evt[SRC_ST]  = selftest_fail_i;
        evt[SRC_OFS] = offset_fault_i;
    end

    fsr_boot_fsm u_boot (
        .clk        (clk),
        .rst_n      (rst_n),
        .done_i     (init_done_i),
        .rd_i       (stat_rd_i),
        .init_o     (init_f),
        .rst_flag_o (rst_f)
    );

    for (genvar g = 0; g < N_SRC; g++) begin : g_src
        localparam clr_mode_e M =
            (g == SRC_OTP || g == SRC_WLK) ? CLR_NEVER : CLR_ON_READ;
        fsr_fault_cell #(.MODE(M)) u_cell (
            .clk   (clk),
            .rst_n (rst_n),
            .evt_i (evt[g]),
            .rd_i  (stat_rd_i),
            .q_o   (src[g])
        );
    end

    fsr_resp_arb u_arb (
        .busy_i      (init_f | rst_f),
        .src_i       (src),
        .resp_o      (resp_o),
        .arm_inh_o   (arm_inhibit_o),
        .pulse_dis_o (pulse_dis_o)
    );

    assign stat_o = {src[SRC_OFS],
                     src[SRC_OTP] | src[SRC_WLK] | src[SRC_WOP] | src[SRC_ST],
                     rst_f, init_f};

endmodule

// File: rtl/fsr_fault_arbiter_chk.sv
module fsr_fault_arbiter_chk
    import fsr_pkg::*;
(
    input logic              clk,
    input logic              rst_n,
    input logic              init_done_i,
    input logic              stat_rd_i,
    input logic              lock_i,
    input logic              otp_crc_fail_i,
    input logic              wr_crc_fail_i,
    input logic              selftest_fail_i,
    input logic              offset_fault_i,
    input logic [STAT_W-1:0] stat_o,
    input logic [RESP_W-1:0] resp_o,
    input logic              arm_inhibit_o,
    input logic              pulse_dis_o
);

    p_init_clears_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (stat_o[0] && init_done_i) |=> !stat_o[0]);

    p_init_no_reset_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !stat_o[0] |=> !stat_o[0]);

    p_rst_read_clears_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (stat_o[1] && stat_rd_i) |=> !stat_o[1]);

    p_boot_response_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (stat_o[0] || stat_o[1]) |-> (resp_o == RESP_IEP && pulse_dis_o && arm_inhibit_o));

    p_otp_sets_r5: assert property (@(posedge clk) disable iff (!rst_n)
        otp_crc_fail_i |=> stat_o[2]);

    p_locked_crc_sets_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_crc_fail_i && lock_i) |=> stat_o[2]);

    p_offset_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (stat_o[3] && !stat_rd_i) |=> stat_o[3]);

    p_pulse_on_fault_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (!stat_o[0] && !stat_o[1]) |-> !pulse_dis_o);

    p_ste_exclusive_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (resp_o == RESP_STE) |-> (stat_o[2] && !stat_o[3] && !stat_o[1] && !stat_o[0]));

    p_event_beats_read_r12: assert property (@(posedge clk) disable iff (!rst_n)
        (offset_fault_i || selftest_fail_i) |=> (stat_o[2] || stat_o[3]));

endmodule

bind fsr_fault_arbiter fsr_fault_arbiter_chk u_chk (.*);

// File: tb/fsr_fault_arbiter_test.sv
module fsr_fault_arbiter_test;
    import fsr_pkg::*;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic done = 1'b0, rd = 1'b0, lk = 1'b0;
    logic otp = 1'b0, wcrc = 1'b0, st = 1'b0, ofs = 1'b0;
    logic [STAT_W-1:0] stat_o;
    logic [RESP_W-1:0] resp_o;
    logic arm_o, pdis_o;

    int checks = 0;
    int errors = 0;
    bit finished = 1'b0;

    // reference flags
    bit m_init, m_rst, m_otp, m_wlk, m_wop, m_st, m_ofs;

    always #2.5 clk = ~clk;

    fsr_fault_arbiter uut (
        .clk(clk), .rst_n(rst_n), .init_done_i(done), .stat_rd_i(rd),
        .lock_i(lk), .otp_crc_fail_i(otp), .wr_crc_fail_i(wcrc),
        .selftest_fail_i(st), .offset_fault_i(ofs),
        .stat_o(stat_o), .resp_o(resp_o),
        .arm_inhibit_o(arm_o), .pulse_dis_o(pdis_o)
    );

    function automatic logic [3:0] exp_stat();
        return {m_ofs, m_otp | m_wlk | m_wop | m_st, m_rst, m_init};
    endfunction

    function automatic logic [1:0] exp_resp();
        if (m_init | m_rst | m_otp | m_wlk | m_wop | m_ofs) return RESP_IEP;
        if (m_st) return RESP_STE;
        return RESP_NORMAL;
    endfunction

    task automatic chk(input string tag, input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
        end
    endtask

    task automatic check_all(input string tag);
        chk(tag, "stat", stat_o, exp_stat());
        chk(tag, "resp", resp_o, exp_resp());
        chk(tag, "arm_inhibit", arm_o,
            m_init | m_rst | m_otp | m_wlk | m_wop | m_st | m_ofs);
        chk(tag, "pulse_dis", pdis_o, m_init | m_rst);
    endtask

    task automatic do_reset(input string tag);
        @(negedge clk);
        rst_n = 1'b0;
        {done, rd, lk, otp, wcrc, st, ofs} = '0;
        repeat (2) @(negedge clk);
        m_init = 1; m_rst = 1;
        {m_otp, m_wlk, m_wop, m_st, m_ofs} = '0;
        rst_n = 1'b1;
        #1 check_all(tag);
    endtask

    task automatic step(input bit d, r, l, o, w, s, f, input string tag);
        @(negedge clk);
        done = d; rd = r; lk = l; otp = o; wcrc = w; st = s; ofs = f;
        #1;
        if (r) chk("R3", "read data before clear", stat_o, exp_stat());
        @(posedge clk);
        m_init = m_init & ~d;
        m_rst  = m_rst & ~r;
        m_otp  = m_otp | o;
        m_wlk  = m_wlk | (w & l);
        m_wop  = (w & ~l) ? 1'b1 : (r ? 1'b0 : m_wop);
        m_st   = s ? 1'b1 : (r ? 1'b0 : m_st);
        m_ofs  = f ? 1'b1 : (r ? 1'b0 : m_ofs);
        #1 check_all(tag);
    endtask

    initial begin
        #(200000 * 5);
        if (!finished) begin
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd1234));
        do_reset("R1");
        step(0,0,0,0,0,0,0, "R1");
        step(0,1,0,0,0,0,0, "R3");   // reset flag clears, init stays
        step(0,0,0,0,0,0,0, "R4");
        step(1,0,0,0,0,0,0, "R2");
        step(0,0,0,0,0,0,0, "R4");
        // self-test
        step(0,0,0,0,0,1,0, "R8");
        step(0,0,0,0,0,1,0, "R10");
        step(0,1,0,0,0,1,0, "R12");
        step(0,0,0,0,0,0,0, "R8");
        step(0,1,0,0,0,0,0, "R8");
        // offset overlapping self-test
        step(0,0,0,0,0,1,1, "R11");
        step(0,0,0,0,0,0,0, "R9");
        step(0,1,0,0,0,0,1, "R12");
        step(0,1,0,0,0,0,0, "R9");
        // unlocked writable CRC
        step(0,0,0,0,1,0,0, "R7");
        step(0,1,0,0,1,0,0, "R7");
        step(0,1,0,0,0,0,0, "R7");
        // locked writable CRC
        step(0,0,1,0,1,0,0, "R6");
        step(0,1,1,0,0,0,0, "R6");
        step(0,1,0,0,0,0,0, "R6");
        do_reset("R6");
        step(1,1,0,0,0,0,0, "R2");
        // shadow CRC
        step(0,0,0,1,0,0,0, "R5");
        step(0,1,0,0,0,0,0, "R5");
        step(0,1,0,0,0,0,0, "R5");
        do_reset("R1");
        // random traffic
        for (int i = 0; i < 4000; i++) begin
            if ($urandom_range(0, 499) == 0) do_reset("R1");
            else step($urandom_range(0, 9) == 0, $urandom_range(0, 3) == 0,
                      $urandom_range(0, 1) == 0, $urandom_range(0, 299) == 0,
                      $urandom_range(0, 39) == 0, $urandom_range(0, 19) == 0,
                      $urandom_range(0, 19) == 0, "R12");
        end
        finished = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule